// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose Pin Bank

This block controls a bank of up to 32 general-purpose pins through a 32-bit register bus. Each pin is set on its own as a plain input, a driven output, or an interrupt source. An interrupt source can trigger on a high level or a low level, or on a rising or a falling edge. A build-time option adds triggering on both edges. Every pin has one bit at the same position in every register.

Pin inputs pass through a two-flop synchronizer before anything uses them. Edge events are held in a status bit until software clears them with a write-one-to-clear register. Level events simply follow the pin. Status bits are gated by a per-pin enable and ORed into one registered interrupt request.

The enable has two write ports. One register can only take enables away, and the other can only grant them. Software can therefore mask or unmask a single pin without first reading the register. The chatter-filter register is plain storage and has no effect on the pins.

Top module: `gpio_bank`

## Requirements
- R1: After reset every register reads as zero, `pin_oe` is all zero and `irq` is 0. This means all pins are inputs, in general mode, with positive logic, level sense and no enables.
- R2: A bus write (`bus_sel`=1, `bus_wr`=1) takes effect at the clock edge. A read (`bus_sel`=1, `bus_wr`=0) returns the value on `bus_rdata` after the next edge. The offsets are:
  - 0x00 interrupt-mode select (1 = interrupt input)
  - 0x04 direction (1 = output)
  - 0x08 output data
  - 0x0C input data
  - 0x10 status
  - 0x14 status clear
  - 0x18 enable-clearing mask
  - 0x1C enable-setting
  - 0x20 polarity (1 = low / falling)
  - 0x24 sense kind (1 = edge)
  - 0x28 filter storage
  - 0x4C both-edge select

  The offsets 0x14 and 0x1C read as zero.
- R3: The input data register returns each pin's value as sampled through two synchronizer flops.
- R4: `pin_out` equals the output data register. A bit of `pin_oe` is 1 only for a pin with interrupt-mode bit 0 and direction bit 1.
- R5: For an interrupt pin with sense-kind bit 0, the status bit equals the synchronized pin XOR its polarity bit, and it needs no clear.
- R6: For an interrupt pin with sense-kind bit 1 and both-edge bit 0, a rising edge (polarity 0) or a falling edge (polarity 1) sets the status bit. The bit stays set until a 1 is written to that bit of the clear register. Zero bits in a clear write have no effect.
- R7: When the both-edge option is built in, both-edge bit 1 makes an edge-mode pin trigger on either transition. When the option is left out, the both-edge register reads zero, ignores writes, and pins sense a single edge.
- R8: A write to the mask register at 0x18 clears the enable of every bit written as 0 and leaves bits written as 1 unchanged. Reading it returns the enables, with 1 meaning enabled.
- R9: A write to 0x1C sets the enable of every bit written as 1. Zero bits leave the enable unchanged.
- R10: `irq` is the OR over all pins of status AND enable, registered one cycle.
- R11: Status bits of pins in general I/O mode read as 0, whatever their polarity, sense-kind and pin values.
- R12: The filter register stores and reads back its pin bits and changes no other behaviour.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_PINS | Asynchronous pin inputs |
| pin_out | output | NUM_PINS | Output values to the pads |
| pin_oe | output | NUM_PINS | Output enables to the pads |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds two instances side by side with NUM_PINS=4. One has both-edge sensing built in and the other does not, and both receive every bus access. With only four pins, the sweep can cover all eight combinations of polarity, sense kind and both-edge bit. Each combination is driven through a sixteen-step pin sequence in which every pin sees rising edges, falling edges and steady intervals. A bench model predicts each status value arithmetically, for both builds at once, including partial clears. Short directed sequences cover the remaining behaviour: the two enable write ports, direction and output enable, filter storage, and the zero status of non-interrupt pins.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int GB_ADDR_W = 7;
  localparam int GB_DATA_W = 32;
  localparam int GB_MAX_PINS = 32;

  localparam logic [GB_ADDR_W-1:0] OFS_MODE   = 7'h00;
  localparam logic [GB_ADDR_W-1:0] OFS_DIR    = 7'h04;
  localparam logic [GB_ADDR_W-1:0] OFS_OUT    = 7'h08;
  localparam logic [GB_ADDR_W-1:0] OFS_IN     = 7'h0C;
  localparam logic [GB_ADDR_W-1:0] OFS_STAT   = 7'h10;
  localparam logic [GB_ADDR_W-1:0] OFS_CLR    = 7'h14;
  localparam logic [GB_ADDR_W-1:0] OFS_MASK   = 7'h18;
  localparam logic [GB_ADDR_W-1:0] OFS_UNMASK = 7'h1C;
  localparam logic [GB_ADDR_W-1:0] OFS_POL    = 7'h20;
  localparam logic [GB_ADDR_W-1:0] OFS_KIND   = 7'h24;
  localparam logic [GB_ADDR_W-1:0] OFS_FILT   = 7'h28;
  localparam logic [GB_ADDR_W-1:0] OFS_BOTH   = 7'h4C;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_bank_sense.sv
module gpio_bank_sense #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_sync,
  input  logic [NUM_PINS-1:0] irq_mode,
  input  logic [NUM_PINS-1:0] neg_logic,
  input  logic [NUM_PINS-1:0] edge_kind,
  input  logic [NUM_PINS-1:0] any_edge,
  input  logic [NUM_PINS-1:0] clr_req,
  output logic [NUM_PINS-1:0] status
);
  logic [NUM_PINS-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= pin_sync;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic rise, fall, hit, edge_on, held_q;

    assign rise    = pin_sync[i] & ~prev_q[i];
    assign fall    = ~pin_sync[i] & prev_q[i];
    assign hit     = any_edge[i] ? (rise | fall) : (neg_logic[i] ? fall : rise);
    assign edge_on = irq_mode[i] & edge_kind[i];

    // a new edge wins over a clear arriving in the same cycle
    always_ff @(posedge clk) begin
      if (rst || !edge_on) held_q <= 1'b0;
      else if (hit)        held_q <= 1'b1;
      else if (clr_req[i]) held_q <= 1'b0;
    end

    assign status[i] = irq_mode[i] &
                       (edge_kind[i] ? held_q : (pin_sync[i] ^ neg_logic[i]));
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS  = 32,
  parameter bit BOTH_EDGE = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [GB_ADDR_W-1:0] bus_addr,
  input  logic [GB_DATA_W-1:0] bus_wdata,
  output logic [GB_DATA_W-1:0] bus_rdata,
  input  logic [NUM_PINS-1:0]  pin_in,
  output logic [NUM_PINS-1:0]  pin_out,
  output logic [NUM_PINS-1:0]  pin_oe,
  output logic                 irq
);
  localparam int W = NUM_PINS;

  logic [W-1:0] mode_q, dir_q, out_q, pol_q, kind_q, filt_q, en_q, both_q;
  logic [W-1:0] pin_sync, status, clr_vec, wbits;
  logic         wr_en, rd_en;
  logic [GB_DATA_W-1:0] rd_mux, rdata_q;
  logic [W-1:0] oe_q;
  logic         irq_q;

  assign wr_en = bus_sel & bus_wr;
  assign rd_en = bus_sel & ~bus_wr;
  assign wbits = bus_wdata[W-1:0];

  gpio_bank_sync #(.WIDTH(W)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pin_in),
    .sync_out (pin_sync)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      dir_q  <= '0;
      out_q  <= '0;
      pol_q  <= '0;
      kind_q <= '0;
      filt_q <= '0;
      en_q   <= '0;
    end else if (wr_en) begin
      case (bus_addr)
        OFS_MODE:   mode_q <= wbits;
        OFS_DIR:    dir_q  <= wbits;
        OFS_OUT:    out_q  <= wbits;
        OFS_POL:    pol_q  <= wbits;
        OFS_KIND:   kind_q <= wbits;
        OFS_FILT:   filt_q <= wbits;
        OFS_MASK:   en_q   <= en_q & wbits;
        OFS_UNMASK: en_q   <= en_q | wbits;
        default: ;
      endcase
    end
  end

  if (BOTH_EDGE) begin : g_both
    logic [W-1:0] both_r;
    always_ff @(posedge clk) begin
      if (rst) both_r <= '0;
      else if (wr_en && bus_addr == OFS_BOTH) both_r <= wbits;
    end
    assign both_q = both_r;
  end else begin : g_no_both
    assign both_q = '0;
  end

  assign clr_vec = (wr_en && bus_addr == OFS_CLR) ? wbits : '0;

  gpio_bank_sense #(.NUM_PINS(W)) u_sense (
    .clk       (clk),
    .rst       (rst),
    .pin_sync  (pin_sync),
    .irq_mode  (mode_q),
    .neg_logic (pol_q),
    .edge_kind (kind_q),
    .any_edge  (both_q),
    .clr_req   (clr_vec),
    .status    (status)
  );

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFS_MODE: rd_mux[W-1:0] = mode_q;
      OFS_DIR:  rd_mux[W-1:0] = dir_q;
      OFS_OUT:  rd_mux[W-1:0] = out_q;
      OFS_IN:   rd_mux[W-1:0] = pin_sync;
      OFS_STAT: rd_mux[W-1:0] = status;
      OFS_MASK: rd_mux[W-1:0] = en_q;
      OFS_POL:  rd_mux[W-1:0] = pol_q;
      OFS_KIND: rd_mux[W-1:0] = kind_q;
      OFS_FILT: rd_mux[W-1:0] = filt_q;
      OFS_BOTH: rd_mux[W-1:0] = both_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      oe_q    <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (rd_en) rdata_q <= rd_mux;
      oe_q  <= dir_q & ~mode_q;
      irq_q <= |(status & en_q);
    end
  end

  assign bus_rdata = rdata_q;
  assign pin_out   = out_q;
  assign pin_oe    = oe_q;
  assign irq       = irq_q;
endmodule

// File: rtl/gpio_bank_checker.sv
module gpio_bank_checker
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS  = 32,
  parameter bit BOTH_EDGE = 1'b1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_sel,
  input logic                 bus_wr,
  input logic [GB_ADDR_W-1:0] bus_addr,
  input logic [NUM_PINS-1:0]  mode_q,
  input logic [NUM_PINS-1:0]  en_q,
  input logic [NUM_PINS-1:0]  both_q,
  input logic [NUM_PINS-1:0]  status,
  input logic [NUM_PINS-1:0]  pin_oe,
  input logic                 irq
);
  assert_oe_only_gpio_R4: assert property (@(posedge clk) disable iff (rst)
    (pin_oe & $past(mode_q)) == '0);

  assert_status_gpio_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (status & ~mode_q) == '0);

  assert_mask_never_sets_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && bus_addr == OFS_MASK) |=> ((en_q & ~$past(en_q)) == '0));

  assert_unmask_never_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && bus_addr == OFS_UNMASK) |=> (($past(en_q) & ~en_q) == '0));

  assert_irq_has_source_R10: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|(status & en_q)));

  assert_both_absent_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (!BOTH_EDGE) |-> (both_q == '0));
endmodule

bind gpio_bank gpio_bank_checker #(.NUM_PINS(NUM_PINS), .BOTH_EDGE(BOTH_EDGE)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .mode_q   (mode_q),
  .en_q     (en_q),
  .both_q   (both_q),
  .status   (status),
  .pin_oe   (pin_oe),
  .irq      (irq)
);

// File: tb/gpio_bank_bench.sv
module gpio_bank_bench;
  localparam int NP = 4;
  localparam logic [NP-1:0] ALL = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [6:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata_a, rdata_b;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] out_a, oe_a, out_b, oe_b;
  logic irq_a, irq_b;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_bank #(.NUM_PINS(NP), .BOTH_EDGE(1'b1)) u_gpio_bank (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .pin_in(pin_in),
    .pin_out(out_a), .pin_oe(oe_a), .irq(irq_a));

  gpio_bank #(.NUM_PINS(NP), .BOTH_EDGE(1'b0)) u_gpio_bank_single (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .pin_in(pin_in),
    .pin_out(out_b), .pin_oe(oe_b), .irq(irq_b));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] va, output logic [31:0] vb);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    va = rdata_a; vb = rdata_b;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b;
    logic [6:0] offs [12];
    offs = '{7'h00, 7'h04, 7'h08, 7'h0C, 7'h10, 7'h14, 7'h18, 7'h1C, 7'h20, 7'h24, 7'h28, 7'h4C};
    idle(4);
    rst = 1'b0;
    idle(2);

    // R1: reset state
    foreach (offs[k]) begin
      rd(offs[k], a, b);
      check("R1 reg A", a, 0);
      check("R1 reg B", b, 0);
    end
    check("R1 oe", {28'd0, oe_a}, 0);
    check("R1 irq", {31'd0, irq_a}, 0);

    // R2, R12, R11: general registers, pins still general I/O
    wr(7'h04, 32'h5); wr(7'h08, 32'hA); wr(7'h20, 32'hF); wr(7'h24, 32'h3);
    wr(7'h28, 32'hFFFF_FFF6);
    rd(7'h04, a, b); check("R2 dir", a, 32'h5);
    rd(7'h08, a, b); check("R2 out", a, 32'hA);
    rd(7'h20, a, b); check("R2 pol", a, 32'hF);
    rd(7'h24, a, b); check("R2 kind", a, 32'h3);
    rd(7'h28, a, b); check("R12 filt", a, 32'h6);
    rd(7'h10, a, b); check("R11 status gpio", a, 32'h0);
    check("R11 irq", {31'd0, irq_a}, 0);
    check("R4 pin_out", {28'd0, out_a}, 32'hA);
    check("R4 oe gpio", {28'd0, oe_a}, 32'h5);
    wr(7'h00, 32'h3);
    idle(2);
    check("R4 oe irq mode", {28'd0, oe_a}, 32'h4);
    wr(7'h00, 32'h0); wr(7'h20, 32'h0); wr(7'h24, 32'h0);
    wr(7'h28, 32'h0);

    // R3: synchronized input
    for (int v = 0; v < 16; v++) begin
      pin_in = v[NP-1:0];
      idle(3);
      rd(7'h0C, a, b);
      check("R3 indata", a, v);
    end

    // R8, R9: enable write ports
    wr(7'h1C, 32'h6); rd(7'h18, a, b); check("R9 set", a, 32'h6);
    wr(7'h1C, 32'h1); rd(7'h18, a, b); check("R9 set keeps", a, 32'h7);
    wr(7'h18, 32'hFFFF_FFFD); rd(7'h18, a, b); check("R8 clear one", a, 32'h5);
    wr(7'h18, 32'hF); rd(7'h18, a, b); check("R8 ones keep", a, 32'h5);
    rd(7'h1C, a, b); check("R2 unmask reads 0", a, 0);
    rd(7'h14, a, b); check("R2 clear reads 0", a, 0);

    // R10: level high, partial enable
    pin_in = 4'h2;
    wr(7'h00, 32'hF);
    idle(4);
    rd(7'h10, a, b); check("R5 level", a, 32'h2);
    check("R10 masked", {31'd0, irq_a}, 0);
    wr(7'h1C, 32'h2);
    idle(2);
    check("R10 unmasked", {31'd0, irq_a}, 1);
    wr(7'h18, 32'h0);
    idle(2);
    check("R10 masked again", {31'd0, irq_a}, 0);

    // R7: both-edge register presence
    wr(7'h4C, 32'h9);
    rd(7'h4C, a, b);
    check("R7 both present", a, 32'h9);
    check("R7 both absent", b, 32'h0);

    // sweep over polarity, sense kind, both-edge
    for (int c = 0; c < 8; c++) begin
      logic [NP-1:0] polm, kindm, bothm, prev, cur, latA, latB, expA, expB, clr;
      logic [NP-1:0] rise, fall, hitA, hitB;
      string tagA, tagB;
      polm  = c[0] ? ALL : '0;
      kindm = c[1] ? ALL : '0;
      bothm = c[2] ? ALL : '0;
      tagA = !c[1] ? "R5" : (c[2] ? "R7" : "R6");
      tagB = !c[1] ? "R5" : (c[2] ? "R7 absent" : "R6");
      pin_in = '0;
      idle(4);
      wr(7'h00, 0); wr(7'h20, polm); wr(7'h24, kindm); wr(7'h4C, bothm);
      wr(7'h00, ALL); wr(7'h14, ALL); wr(7'h1C, ALL);
      latA = '0; latB = '0; prev = '0;
      for (int s = 0; s < 16; s++) begin
        cur = 4'((s * 7 + 3) % 16);
        pin_in = cur;
        idle(6);
        rise = cur & ~prev;
        fall = ~cur & prev;
        hitB = c[0] ? fall : rise;
        hitA = c[2] ? (rise | fall) : hitB;
        if (c[1]) begin
          latA = latA | hitA; latB = latB | hitB;
          expA = latA; expB = latB;
        end else begin
          expA = cur ^ polm; expB = cur ^ polm;
        end
        check("R10 irq A", {31'd0, irq_a}, {31'd0, |expA});
        check("R10 irq B", {31'd0, irq_b}, {31'd0, |expB});
        rd(7'h10, a, b);
        check(tagA, a, {28'd0, expA});
        check(tagB, b, {28'd0, expB});
        clr = s[NP-1:0];
        wr(7'h14, {28'd0, clr});
        latA = latA & ~clr; latB = latB & ~clr;
        prev = cur;
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule